// File: doc/BRIEF.md
# Two-TAP Debug Scan Chain with Halt Unlock

This block is the target side of a JTAG port that carries two test access ports in series. The port next to TDI has a 4-bit instruction register. It offers a bypass bit, an identification register, a scan-chain selector, a chain-access instruction, and a private instruction. The private instruction reaches a 2-bit unlock register. Scan chain 2, reached through the selector and the access instruction, holds a debug-request bit that the debugger writes and returns the core's debug-acknowledge when read. The port next to TDO has an 8-bit instruction register, and every value in it acts as bypass.

A debug request set through chain 2 reaches the core only after the unlock register has been updated with the value 2'b10. Until then the request is stored but has no effect on the output. Once unlocked, the block stays unlocked through any number of halt and resume requests and through a TMS-driven return to Test-Logic-Reset. Only the asynchronous test reset clears the unlock state. All logic is clocked by TCK alone, so the chain works while the system clock is stopped.

A debugger uses it as follows. After a test reset it scans the private opcode and the unlock value. It then selects chain 2 and writes the request bit. Finally it polls the acknowledge bit through the same chain.

Top module: `dual_tap_unlock`

## Requirements
- R1: After test reset (`trst_n` low), `halt_req` is 0 and the first TAP's instruction is IDCODE (4'b1110), so a data scan returns the identification value.
- R2: With the first TAP on IDCODE and the second in bypass, a 33-bit data scan returns 0 as the first bit out, then the 32-bit identification value LSB first (its bit 0 is 1).
- R3: Capture-IR loads 8'h01 into the second TAP and 4'b0001 into the first. A 12-bit IR scan therefore returns 8'h01 in its first eight bits out and 4'b0001 in the last four.
- R4: Opcode 4'b1111 in the first TAP, with any value in the second TAP's IR (8'h00 included), gives a 2-bit data path. Both bits capture 0, and data entering TDI leaves TDO two shifts later.
- R5: Opcode 4'b1011 selects a 2-bit unlock register that captures {1'b0, unlock state}. An Update-DR holding 2'b10 (bit 1 set, bit 0 clear) sets the unlock state. The values 2'b00, 2'b01 and 2'b11 leave it unchanged.
- R6: While locked, writing the request bit to 1 through chain 2 leaves `halt_req` at 0.
- R7: Once unlocked, `halt_req` follows the chain 2 request bit (bit 0) after each Update-DR, for repeated set and clear without a further unlock.
- R8: Opcode 4'b0010 loads a 4-bit chain number. Under opcode 4'b1100 with chain 2 selected, the data register is 2 bits wide. Its bit 0 captures `core_ack` and its bit 1 captures the stored request bit.
- R9: Test reset clears the unlock state and the request bit. A later request without a new unlock leaves `halt_req` at 0.
- R10: Five TCK cycles with TMS high return the first TAP to IDCODE but keep the unlock state and the request bit.
- R11: Under opcode 4'b1100 with a chain other than 2 selected, the data register is one bit that captures 0, and writes through it do not change `halt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, the only clock of the block |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in, enters the 4-bit-IR TAP |
| trst_n | input | 1 | Asynchronous active-low test reset, also clears the unlock |
| core_ack | input | 1 | Debug acknowledge from the core |
| tdo | output | 1 | Serial data out of the 8-bit-IR TAP |
| halt_req | output | 1 | Debug request to the core, gated by the unlock |

## Verification
Several unlock values are tried in turn: 2'b01, 2'b11 and 2'b00 before 2'b10. This separates a decoder that matches one value exactly from one that tests a single bit. The request bit is written 1 before the unlock and toggled after it, which tells a stored-but-gated request apart from a request that is discarded. A Test-Logic-Reset reached through TMS and a pulse on the reset pin are each followed by both an IDCODE read and a request write. This shows which state each kind of reset clears. Bypass is scanned with the second TAP holding 8'h00 as well as all ones, so the test fails if any of its opcodes decodes to something other than bypass.

// File: rtl/dual_tap_unlock.sv
module dual_tap_unlock #(
  parameter logic [31:0] ID_VALUE  = 32'h0A5C_3001,
  parameter int          IR1_W     = 4,
  parameter int          IR2_W     = 8,
  parameter int          CHAIN_W   = 4,
  parameter int          DBG_CHAIN = 2
) (
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic trst_n,
  input  logic core_ack,
  output logic tdo,
  output logic halt_req
);
  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PDR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PIR, S_EX2IR, S_UPIR
  } tap_st_t;

  localparam logic [IR1_W-1:0] OP_SCAN   = IR1_W'(4'b0010);
  localparam logic [IR1_W-1:0] OP_ACCESS = IR1_W'(4'b1100);
  localparam logic [IR1_W-1:0] OP_UNLOCK = IR1_W'(4'b1011);
  localparam logic [IR1_W-1:0] OP_IDCODE = IR1_W'(4'b1110);
  localparam logic [1:0]       UNLOCK_KEY = 2'b10;

  tap_st_t st, st_nx;
  logic [IR1_W-1:0]   ir1, ir1_sh;
  logic [IR2_W-1:0]   ir2_sh;
  logic [31:0]        id_sh;
  logic [CHAIN_W-1:0] chain_sel, chain_sh;
  logic [1:0]         dbg_sh, key_sh;
  logic               byp1, byp2, req_bit, unlocked;
  logic               dbg_sel, tap1_out;

  always_comb begin
    unique case (st)
      S_TLR:   st_nx = tms ? S_TLR   : S_RTI;
      S_RTI:   st_nx = tms ? S_SELDR : S_RTI;
      S_SELDR: st_nx = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: st_nx = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  st_nx = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: st_nx = tms ? S_UPDR  : S_PDR;
      S_PDR:   st_nx = tms ? S_EX2DR : S_PDR;
      S_EX2DR: st_nx = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  st_nx = tms ? S_SELDR : S_RTI;
      S_SELIR: st_nx = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: st_nx = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  st_nx = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: st_nx = tms ? S_UPIR  : S_PIR;
      S_PIR:   st_nx = tms ? S_EX2IR : S_PIR;
      S_EX2IR: st_nx = tms ? S_UPIR  : S_SHIR;
      default: st_nx = tms ? S_SELDR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= S_TLR;
    else         st <= st_nx;

  assign dbg_sel = (ir1 == OP_ACCESS) && (chain_sel == CHAIN_W'(DBG_CHAIN));

  // instruction registers, TAP1 feeds TAP2 during Shift-IR
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      ir1 <= OP_IDCODE; ir1_sh <= '0; ir2_sh <= '0;
    end else begin
      case (st)
        S_TLR:   ir1 <= OP_IDCODE;
        S_CAPIR: begin ir1_sh <= IR1_W'(1); ir2_sh <= IR2_W'(1); end
        S_SHIR:  begin
          ir1_sh <= {tdi, ir1_sh[IR1_W-1:1]};
          ir2_sh <= {ir1_sh[0], ir2_sh[IR2_W-1:1]};
        end
        S_UPIR:  ir1 <= ir1_sh;
        default: ;
      endcase
    end

  // TAP1 data registers
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      byp1 <= 1'b0; id_sh <= '0; chain_sh <= '0; dbg_sh <= '0; key_sh <= '0;
      chain_sel <= '0; req_bit <= 1'b0; unlocked <= 1'b0;
    end else begin
      if (st == S_CAPDR) begin
        byp1 <= 1'b0;
        unique case (1'b1)
          ir1 == OP_IDCODE: id_sh    <= ID_VALUE;
          ir1 == OP_SCAN:   chain_sh <= chain_sel;
          ir1 == OP_UNLOCK: key_sh   <= {1'b0, unlocked};
          dbg_sel:          dbg_sh   <= {req_bit, core_ack};
          default: ;
        endcase
      end else if (st == S_SHDR) begin
        byp1 <= tdi;
        unique case (1'b1)
          ir1 == OP_IDCODE: id_sh    <= {tdi, id_sh[31:1]};
          ir1 == OP_SCAN:   chain_sh <= {tdi, chain_sh[CHAIN_W-1:1]};
          ir1 == OP_UNLOCK: key_sh   <= {tdi, key_sh[1]};
          dbg_sel:          dbg_sh   <= {tdi, dbg_sh[1]};
          default: ;
        endcase
      end else if (st == S_UPDR) begin
        if (ir1 == OP_SCAN) chain_sel <= chain_sh;
        if (ir1 == OP_UNLOCK && key_sh == UNLOCK_KEY) unlocked <= 1'b1;
        if (dbg_sel) req_bit <= dbg_sh[0];
      end
    end

  always_comb begin
    if (st == S_SHIR)              tap1_out = ir1_sh[0];
    else if (ir1 == OP_IDCODE)     tap1_out = id_sh[0];
    else if (ir1 == OP_SCAN)       tap1_out = chain_sh[0];
    else if (ir1 == OP_UNLOCK)     tap1_out = key_sh[0];
    else if (dbg_sel)              tap1_out = dbg_sh[0];
    else                           tap1_out = byp1;
  end

  // TAP2: every opcode decodes to bypass
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)            byp2 <= 1'b0;
    else if (st == S_CAPDR) byp2 <= 1'b0;
    else if (st == S_SHDR)  byp2 <= tap1_out;

  assign tdo      = (st == S_SHIR) ? ir2_sh[0] : byp2;
  assign halt_req = req_bit & unlocked;

  assert_unlock_sticky_R5: assert property (@(posedge tck) disable iff (!trst_n)
    unlocked |=> unlocked);
  assert_unlock_cause_R5: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(unlocked) |-> $past(st == S_UPDR && ir1 == OP_UNLOCK && key_sh == UNLOCK_KEY));
  assert_halt_on_update_R7: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(halt_req) |-> $past(st == S_UPDR));
  assert_tlr_idcode_R10: assert property (@(posedge tck) disable iff (!trst_n)
    $past(st == S_TLR) |-> ir1 == OP_IDCODE);
  assert_bypass_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
    $past(st == S_CAPDR) |-> !byp2);
endmodule

// File: tb/dual_tap_unlock_bench.sv
module dual_tap_unlock_bench;
  localparam logic [31:0] ID = 32'h0A5C_3001;
  logic tck = 0, tms = 1, tdi = 0, trst_n = 0, core_ack = 0;
  logic tdo, halt_req;
  int n_chk = 0, n_bad = 0;

  dual_tap_unlock u_dual_tap_unlock (.tck, .tms, .tdi, .trst_n, .core_ack, .tdo, .halt_req);

  always #2.5 tck = ~tck;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic m, logic d, output logic o);
    @(negedge tck); tms = m; tdi = d; #1 o = tdo;
    @(posedge tck);
  endtask

  task automatic scan(bit ir, int len, logic [40:0] din, output logic [40:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o);
    if (ir) step(1, 0, o);
    step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
    #1;
  endtask

  task automatic set_ir(logic [3:0] op1, logic [7:0] op2);
    logic [40:0] q;
    scan(1, 12, {29'd0, op1, op2}, q);
  endtask

  task automatic dr1(int len1, logic [39:0] v, output logic [39:0] cap);
    logic [40:0] q;
    scan(0, len1 + 1, {v, 1'b0}, q);
    cap = q[40:1];
    check("R4 trailing bypass", q[0], 0);
  endtask

  task automatic do_reset();
    logic o;
    trst_n = 0; #12; trst_n = 1;
    step(0, 0, o);
  endtask

  task automatic write_req(logic b);
    logic [39:0] c;
    set_ir(4'b0010, 8'hFF); dr1(4, 40'd2, c);
    set_ir(4'b1100, 8'hFF); dr1(2, {38'd0, 1'b0, b}, c);
  endtask

  task automatic t_reset();
    logic [39:0] c;
    do_reset();
    check("R1 halt_req after reset", halt_req, 0);
    dr1(32, 40'd0, c);
    check("R1 R2 idcode", c[31:0], ID);
  endtask

  task automatic t_ir_capture();
    logic [40:0] q;
    scan(1, 12, {29'd0, 4'b1110, 8'hFF}, q);
    check("R3 tap2 capture", q[7:0], 8'h01);
    check("R3 tap1 capture", q[11:8], 4'b0001);
  endtask

  task automatic t_bypass();
    logic [40:0] q;
    foreach (q[i]) q[i] = 0;
    set_ir(4'b1111, 8'h00);
    scan(0, 6, 41'b101101, q);
    check("R4 bypass capture", q[1:0], 2'b00);
    check("R4 bypass delay", q[5:2], 4'b1101);
    set_ir(4'b1111, 8'hFF);
    scan(0, 4, 41'b0110, q);
    check("R4 bypass delay all ones", q[3:2], 2'b10);
  endtask

  task automatic t_locked();
    logic [39:0] c;
    core_ack = 1;
    write_req(1);
    check("R6 locked request ignored", halt_req, 0);
    dr1(2, 40'd1, c);
    check("R8 capture ack and request", c[1:0], 2'b11);
    core_ack = 0;
    dr1(2, 40'd1, c);
    check("R8 capture ack low", c[1:0], 2'b10);
  endtask

  task automatic t_unlock();
    logic [39:0] c;
    set_ir(4'b1011, 8'hFF);
    dr1(2, 40'b01, c);
    check("R5 capture locked", c[1:0], 2'b00);
    check("R5 key 01 rejected", halt_req, 0);
    dr1(2, 40'b11, c);
    check("R5 key 11 rejected", halt_req, 0);
    dr1(2, 40'b00, c);
    check("R5 key 00 rejected", halt_req, 0);
    dr1(2, 40'b10, c);
    check("R5 R7 key 10 accepted", halt_req, 1);
    dr1(2, 40'b00, c);
    check("R5 capture unlocked", c[1:0], 2'b01);
    check("R5 unlock sticky", halt_req, 1);
  endtask

  task automatic t_toggle();
    for (int k = 0; k < 3; k++) begin
      write_req(0);
      check("R7 resume", halt_req, 0);
      write_req(1);
      check("R7 halt again", halt_req, 1);
    end
  endtask

  task automatic t_other_chain();
    logic [39:0] c;
    set_ir(4'b0010, 8'hFF); dr1(4, 40'd3, c);
    check("R11 chain number readback", c[3:0], 4'd2);
    set_ir(4'b1100, 8'hFF); dr1(1, 40'd0, c);
    check("R11 other chain captures 0", c[0], 0);
    check("R11 other chain no effect", halt_req, 1);
  endtask

  task automatic t_tlr();
    logic o;
    logic [39:0] c;
    for (int k = 0; k < 5; k++) step(1, 0, o);
    step(0, 0, o);
    #1;
    check("R10 request kept through TLR", halt_req, 1);
    dr1(32, 40'd0, c);
    check("R10 idcode after TLR", c[31:0], ID);
    write_req(0); write_req(1);
    check("R10 unlock kept through TLR", halt_req, 1);
  endtask

  task automatic t_treset();
    do_reset();
    check("R9 reset clears halt", halt_req, 0);
    write_req(1);
    check("R9 relocked after reset", halt_req, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ir_capture();
    t_bypass();
    t_locked();
    t_unlock();
    t_toggle();
    t_other_chain();
    t_tlr();
    t_treset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule